// File: doc/BRIEF.md
# Sampling ADC Conversion Sequencer

This block is a synchronous controller for an external 14-bit sampling converter that runs its conversion from its own internal oscillator. A request from the user side makes the block pulse a dedicated active-low start strobe. It then waits a fixed number of clock cycles, enough to cover the worst-case conversion time. After that it lowers chip select and read together, like a memory read, latches the result and offers it on a valid/ready output.

The block watches no busy flag. Every timing rule is a down-counter whose length is computed from the clock frequency parameter and a time in nanoseconds, rounded up to whole cycles. The rules are the conversion wait, the acquisition time before the next start, the minimum start-to-start spacing, and the wake-up delays after each power-down mode.

A 2-bit mode input selects the idle state of the converter: active, a light power-down with a short wake-up, or a deep power-down that also turns off the reference and needs a long wake-up. A request made while powered down first leaves the power-down mode, waits out the matching wake-up delay, and then converts. When the block is idle again it returns to the selected mode.

Top module: `adc_seq`

## Requirements
- R1: After reset, the start strobe, chip select and read are high (inactive), valid is low, and both power-down outputs are low.
- R2: A start strobe is low for exactly START_CYC consecutive cycles (at least two), and chip select and read stay high while it is low.
- R3: Chip select and read go low exactly CONV_CYC cycles after the cycle in which the start strobe first goes low.
- R4: Chip select and read stay low together for exactly RD_CYC cycles. The converter data present in the last of those cycles then appears on dout_o with valid_o high, and each request's result arrives in request order.
- R5: Two cycles in which the start strobe first goes low are never fewer than THR_CYC cycles apart.
- R6: A start never begins fewer than ACQ_CYC cycles after the previous read began. With the default parameters, back-to-back starts are therefore exactly max(THR_CYC, CONV_CYC+ACQ_CYC) cycles apart.
- R7: While idle, mode_i = 1 drives nap_o high and mode_i = 2 drives sleep_o high. Values 0 and 3 keep the converter fully active.
- R8: A request made while nap_o is high lowers nap_o, and the start strobe falls exactly NAP_CYC cycles later.
- R9: A request made while sleep_o is high lowers sleep_o, and no start occurs until SLP_CYC cycles after sleep_o fell. When nothing else is pending, the start comes exactly SLP_CYC cycles after.
- R10: A request that arrives while a conversion is running is held and served by exactly one further conversion once the spacing rules allow.
- R11: While valid_o is high and ready_i is low, dout_o and valid_o hold, and no new conversion starts even if a request is pending.
- R12: Each interval in cycles is ceil(t_ns × CLK_HZ / 1e9). At 200 MHz this gives conversion 440, acquisition 80, spacing 500 and light wake-up 40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Sample request, one pulse per sample |
| mode_i | input | 2 | Idle mode: 0 active, 1 light power-down, 2 deep power-down, 3 active |
| ready_i | input | 1 | Consumer accepts dout_o |
| dout_o | output | DW | Latched conversion result |
| valid_o | output | 1 | dout_o holds an unaccepted result |
| convst_n_o | output | 1 | Active-low conversion start strobe |
| cs_n_o | output | 1 | Active-low chip select |
| rd_n_o | output | 1 | Active-low read strobe |
| nap_o | output | 1 | Light power-down request to the converter |
| sleep_o | output | 1 | Deep power-down request to the converter |
| adc_data_i | input | DW | Converter data bus |

## Verification
The main function is exercised with four request patterns. A lone request from active idle isolates the strobe widths and the conversion wait. A second request issued while a conversion is running shows that held requests are served once and that acquisition time, not the start-to-start spacing, sets the interval here. Requests from light and deep power-down separate the two wake-up delays. A request made while the result register is blocked by a stalled consumer shows that backpressure stops new starts and freezes the data. A stub converter returns a different value for each conversion, so any lost, duplicated or reordered result shows up in the scoreboard.

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq #(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned DW         = 14,
  parameter int unsigned START_CYC  = 2,
  parameter int unsigned RD_CYC     = 3,
  parameter int unsigned T_CONV_NS  = 2200,
  parameter int unsigned T_ACQ_NS   = 400,
  parameter int unsigned T_THRU_NS  = 2500,
  parameter int unsigned T_NAP_NS   = 200,
  parameter int unsigned T_SLEEP_NS = 20_000_000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic [1:0]    mode_i,
  input  logic          ready_i,
  output logic [DW-1:0] dout_o,
  output logic          valid_o,
  output logic          convst_n_o,
  output logic          cs_n_o,
  output logic          rd_n_o,
  output logic          nap_o,
  output logic          sleep_o,
  input  logic [DW-1:0] adc_data_i
);
  localparam longint NSPS     = 1_000_000_000;
  localparam longint CONV_CYC = (longint'(T_CONV_NS)  * longint'(CLK_HZ) + NSPS - 1) / NSPS;
  localparam longint ACQ_CYC  = (longint'(T_ACQ_NS)   * longint'(CLK_HZ) + NSPS - 1) / NSPS;
  localparam longint THR_CYC  = (longint'(T_THRU_NS)  * longint'(CLK_HZ) + NSPS - 1) / NSPS;
  localparam longint NAP_CYC  = (longint'(T_NAP_NS)   * longint'(CLK_HZ) + NSPS - 1) / NSPS;
  localparam longint SLP_CYC  = (longint'(T_SLEEP_NS) * longint'(CLK_HZ) + NSPS - 1) / NSPS;
  localparam longint M1   = (CONV_CYC > THR_CYC) ? CONV_CYC : THR_CYC;
  localparam longint M2   = (ACQ_CYC > NAP_CYC) ? ACQ_CYC : NAP_CYC;
  localparam longint M3   = (M1 > M2) ? M1 : M2;
  localparam longint MAXC = (M3 > SLP_CYC) ? M3 : SLP_CYC;
  localparam int     CW   = $clog2(MAXC + 1) + 1;

  localparam logic [CW-1:0] L_START = CW'(START_CYC - 1);
  localparam logic [CW-1:0] L_CONV  = CW'(CONV_CYC - longint'(START_CYC) - 1);
  localparam logic [CW-1:0] L_RD    = CW'(RD_CYC - 1);
  localparam logic [CW-1:0] L_THR   = CW'(THR_CYC - 1);
  localparam logic [CW-1:0] L_ACQ   = CW'(ACQ_CYC - 1);
  localparam logic [CW-1:0] L_NAP   = CW'(NAP_CYC - 1);
  localparam logic [CW-1:0] L_SLP   = CW'(SLP_CYC - 1);

  localparam logic [1:0] PD_ON = 2'd0, PD_NAP = 2'd1, PD_SLP = 2'd2;

  typedef enum logic [1:0] {IDLE, START, CONV, READ} st_t;

  st_t           st;
  logic [1:0]    pd, pd_tgt;
  logic [CW-1:0] cnt, thr, acq, wk, wk_n, wake_len;
  logic          pend, want, go, wake_ld;

  assign want     = pend | req_i;
  assign go       = (st == IDLE) && want && (pd == PD_ON) && (wk == '0) &&
                    (thr == '0) && (acq == '0) && !valid_o;
  assign pd_tgt   = want ? PD_ON :
                    (mode_i == 2'd1) ? PD_NAP :
                    (mode_i == 2'd2) ? PD_SLP : PD_ON;
  assign wake_ld  = (st == IDLE) &&
                    (((pd == PD_SLP) && (pd_tgt != PD_SLP)) ||
                     ((pd == PD_NAP) && (pd_tgt == PD_ON)));
  assign wake_len = (pd == PD_SLP) ? L_SLP : L_NAP;
  assign wk_n     = wk - CW'(wk != '0);

  assign convst_n_o = (st != START);
  assign cs_n_o     = (st != READ);
  assign rd_n_o     = (st != READ);
  assign nap_o      = (pd == PD_NAP);
  assign sleep_o    = (pd == PD_SLP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= IDLE;
      pd      <= PD_ON;
      cnt     <= '0;
      thr     <= '0;
      acq     <= '0;
      wk      <= '0;
      pend    <= 1'b0;
      valid_o <= 1'b0;
      dout_o  <= '0;
    end else begin
      thr  <= thr - CW'(thr != '0);
      acq  <= acq - CW'(acq != '0);
      wk   <= wake_ld ? ((wk_n > wake_len) ? wk_n : wake_len) : wk_n;
      pend <= want & ~go;
      if (valid_o && ready_i) valid_o <= 1'b0;
      if (st == IDLE) pd <= pd_tgt;
      case (st)
        IDLE:
          if (go) begin
            st  <= START;
            cnt <= L_START;
            thr <= L_THR;
          end
        START:
          if (cnt == '0) begin
            st  <= CONV;
            cnt <= L_CONV;
          end else cnt <= cnt - 1'b1;
        CONV:
          if (cnt == '0) begin
            st  <= READ;
            cnt <= L_RD;
            acq <= L_ACQ;
          end else cnt <= cnt - 1'b1;
        READ:
          if (cnt == '0) begin
            st      <= IDLE;
            dout_o  <= adc_data_i;
            valid_o <= 1'b1;
          end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int unsigned CLK_HZ     = 200_000_000,
  parameter int unsigned DW         = 14,
  parameter int unsigned T_CONV_NS  = 2200,
  parameter int unsigned T_ACQ_NS   = 400,
  parameter int unsigned T_THRU_NS  = 2500,
  parameter int unsigned T_NAP_NS   = 200,
  parameter int unsigned T_SLEEP_NS = 20_000_000
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready_i,
  input logic [DW-1:0] dout_o,
  input logic          valid_o,
  input logic          convst_n_o,
  input logic          cs_n_o,
  input logic          rd_n_o,
  input logic          nap_o,
  input logic          sleep_o
);
  localparam longint NSPS     = 1_000_000_000;
  localparam longint CONV_CYC = (longint'(T_CONV_NS)  * longint'(CLK_HZ) + NSPS - 1) / NSPS;
  localparam longint ACQ_CYC  = (longint'(T_ACQ_NS)   * longint'(CLK_HZ) + NSPS - 1) / NSPS;
  localparam longint THR_CYC  = (longint'(T_THRU_NS)  * longint'(CLK_HZ) + NSPS - 1) / NSPS;
  localparam longint NAP_CYC  = (longint'(T_NAP_NS)   * longint'(CLK_HZ) + NSPS - 1) / NSPS;
  localparam longint SLP_CYC  = (longint'(T_SLEEP_NS) * longint'(CLK_HZ) + NSPS - 1) / NSPS;

  logic        cv_q, rd_q, pd_q, sl_q;
  logic        st_fall, rd_fall, pd_fall, sl_fall;
  logic [31:0] since_st, since_rd, since_pd, since_sl;

  assign st_fall = cv_q & ~convst_n_o;
  assign rd_fall = rd_q & ~rd_n_o;
  assign pd_fall = pd_q & ~(nap_o | sleep_o);
  assign sl_fall = sl_q & ~sleep_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cv_q <= 1'b1; rd_q <= 1'b1; pd_q <= 1'b0; sl_q <= 1'b0;
      since_st <= '1; since_rd <= '1; since_pd <= '1; since_sl <= '1;
    end else begin
      cv_q <= convst_n_o;
      rd_q <= rd_n_o;
      pd_q <= nap_o | sleep_o;
      sl_q <= sleep_o;
      since_st <= st_fall ? 32'd1 : (since_st == '1 ? since_st : since_st + 1'b1);
      since_rd <= rd_fall ? 32'd1 : (since_rd == '1 ? since_rd : since_rd + 1'b1);
      since_pd <= pd_fall ? 32'd1 : (since_pd == '1 ? since_pd : since_pd + 1'b1);
      since_sl <= sl_fall ? 32'd1 : (since_sl == '1 ? since_sl : since_sl + 1'b1);
    end
  end

  p_start_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_fall |=> !convst_n_o);
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !convst_n_o |-> (cs_n_o && rd_n_o));
  p_read_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o == rd_n_o);
  p_conv_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall |-> longint'(since_st) == CONV_CYC);
  p_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
    st_fall |-> longint'(since_st) >= THR_CYC);
  p_acquire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_fall |-> longint'(since_rd) >= ACQ_CYC);
  p_nap_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st_fall |-> (!nap_o && !sleep_o && longint'(since_pd) >= NAP_CYC));
  p_sleep_wake_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st_fall |-> longint'(since_sl) >= SLP_CYC);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(dout_o)));
  p_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> convst_n_o);
endmodule

bind adc_seq adc_seq_chk #(
  .CLK_HZ(CLK_HZ), .DW(DW), .T_CONV_NS(T_CONV_NS), .T_ACQ_NS(T_ACQ_NS),
  .T_THRU_NS(T_THRU_NS), .T_NAP_NS(T_NAP_NS), .T_SLEEP_NS(T_SLEEP_NS)
) u_chk (.*);

// File: tb/adc_seq_test.sv
`timescale 1ns/1ps
module adc_seq_test;
  localparam int unsigned CLK_HZ  = 200_000_000;
  localparam int unsigned SLP_NS  = 20_000;
  localparam int          START_E = 2;
  localparam int          RD_E    = 3;

  function automatic longint cyc_of(longint ns);
    return (ns * CLK_HZ + 999_999_999) / 1_000_000_000;
  endfunction

  localparam longint CONV_E = cyc_of(2200);
  localparam longint ACQ_E  = cyc_of(400);
  localparam longint THR_E  = cyc_of(2500);
  localparam longint NAP_E  = cyc_of(200);
  localparam longint SLP_E  = cyc_of(SLP_NS);

  logic        clk = 1'b0, rst_n = 1'b0, req = 1'b0, ready = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic [13:0] dout, adc_data;
  logic        valid, convst_n, cs_n, rd_n, nap, sleep_o;

  adc_seq #(.CLK_HZ(CLK_HZ), .T_SLEEP_NS(SLP_NS)) uut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mode_i(mode), .ready_i(ready),
    .dout_o(dout), .valid_o(valid), .convst_n_o(convst_n), .cs_n_o(cs_n),
    .rd_n_o(rd_n), .nap_o(nap), .sleep_o(sleep_o), .adc_data_i(adc_data));

  always #2.5 clk = ~clk;

  function automatic logic [13:0] smp_of(int k);
    return 14'(k * 3001 + 165);
  endfunction

  // converter stub
  int          nconv = 0;
  logic [13:0] smp = '0;
  always @(negedge convst_n) begin
    smp = smp_of(nconv);
    nconv++;
  end
  assign adc_data = (!cs_n && !rd_n) ? smp : 14'h3FFF;

  int n_chk = 0, n_fail = 0, nreq = 0, n_res = 0, n_start = 0;
  int cyc = 0;
  longint last_start = 0, prev_start = 0, start_len = 0, rd_fall = 0, rd_len = 0;
  longint nap_fall = 0, slp_fall = 0;
  logic cv_p = 1'b1, rd_p = 1'b1, nap_p = 1'b0, slp_p = 1'b0;
  logic [13:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_req();
    @(negedge clk);
    req = 1'b1;
    exp_q.push_back(smp_of(nreq));
    nreq++;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_res(input int n);
    while (n_res < n) @(negedge clk);
  endtask

  always @(posedge clk) cyc <= cyc + 1;

  // monitor and scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (!convst_n && cv_p) begin
        prev_start = last_start; last_start = cyc; n_start++;
      end
      if (convst_n && !cv_p) start_len = cyc - last_start;
      if (!rd_n && rd_p) rd_fall = cyc;
      if (rd_n && !rd_p) rd_len = cyc - rd_fall;
      if (!nap && nap_p) nap_fall = cyc;
      if (!sleep_o && slp_p) slp_fall = cyc;
      if (valid && ready) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected result", dout, -1);
        else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          chk(dout == e, "R4 result data", dout, e);
        end
        n_res++;
      end
    end
    cv_p = convst_n; rd_p = rd_n; nap_p = nap; slp_p = sleep_o;
  end

  initial begin
    repeat (150_000) @(posedge clk);
    chk(0, "watchdog expired", cyc, 150_000);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int s0;
    logic [13:0] d0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(convst_n && cs_n && rd_n, "R1 strobes idle", {convst_n, cs_n, rd_n}, 7);
    chk(!valid && !nap && !sleep_o, "R1 valid and power-down low", {valid, nap, sleep_o}, 0);

    // single request from active idle
    do_req();
    wait_res(1);
    chk(start_len == START_E, "R2 start width", start_len, START_E);
    chk(rd_fall - last_start == CONV_E, "R3 R12 conversion wait", rd_fall - last_start, CONV_E);
    chk(rd_len == RD_E, "R4 read width", rd_len, RD_E);

    // R10: request during conversion is held; R5/R6 spacing
    repeat (600) @(negedge clk);
    do_req();
    repeat (100) @(negedge clk);
    do_req();
    wait_res(3);
    chk(n_start == 3, "R10 one extra conversion", n_start, 3);
    chk(last_start - prev_start >= THR_E, "R5 start spacing", last_start - prev_start, THR_E);
    chk(last_start - prev_start == CONV_E + ACQ_E, "R6 acquisition spacing",
        last_start - prev_start, CONV_E + ACQ_E);

    // light power-down
    repeat (600) @(negedge clk);
    mode = 2'd1;
    repeat (5) @(negedge clk);
    chk(nap && !sleep_o, "R7 light mode outputs", {nap, sleep_o}, 2);
    do_req();
    wait_res(4);
    chk(last_start - nap_fall == NAP_E, "R8 light wake delay", last_start - nap_fall, NAP_E);
    repeat (5) @(negedge clk);
    chk(nap, "R7 light mode restored", nap, 1);

    // deep power-down
    repeat (600) @(negedge clk);
    mode = 2'd2;
    repeat (5) @(negedge clk);
    chk(sleep_o && !nap, "R7 deep mode outputs", {nap, sleep_o}, 1);
    do_req();
    wait_res(5);
    chk(last_start - slp_fall == SLP_E, "R9 deep wake delay", last_start - slp_fall, SLP_E);

    // R11: backpressure
    mode = 2'd0;
    repeat (SLP_E + 100) @(negedge clk);
    ready = 1'b0;
    do_req();
    while (!valid) @(negedge clk);
    d0 = dout;
    s0 = n_start;
    do_req();
    repeat (200) @(negedge clk);
    chk(valid && dout == d0, "R11 result held", dout, d0);
    chk(n_start == s0, "R11 no start while stalled", n_start, s0);
    ready = 1'b1;
    wait_res(7);
    chk(n_start == s0 + 1, "R11 held request served", n_start, s0 + 1);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all results delivered", exp_q.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule